// File: doc/BRIEF.md
# Chainable 16-bit serial command slave

This block is the serial front end of a device that is configured through 16-bit command words. A host drives an active-low select, a serial clock that idles low and a serial data line; the block answers on one serial output with an output enable. All three inputs are asynchronous to the block's system clock. Each passes through a two-flop synchronizer, and the edges of select and of the serial clock are then detected in the system clock domain.

While select is low, every falling edge of the serial clock shifts one input bit into a 16-bit shadow register, most significant bit first. The same register drives the output: a parallel status word is loaded when select falls, and each rising edge of the serial clock presents the next bit. The first 16 output bits are therefore the status word and every later bit is an input bit delayed by 16 clocks. Several devices can be chained this way. When select rises, the last 16 received bits are committed as a one-cycle write strobe carrying a 4-bit address and a 12-bit data field. The commit happens only if the frame held a nonzero multiple of 16 bits and both select edges came while the serial clock was low.

The controller is a four-state machine. `ST_IDLE` (select high) moves to `ST_SHIFT` on a select fall with the clock low, or to `ST_BAD` on a select fall with the clock high. `ST_SHIFT` moves to `ST_COMMIT` on a select rise when the clock is low, the bit count is a multiple of 16 and at least one word arrived. Any other select rise in `ST_SHIFT` returns to `ST_IDLE`. `ST_BAD` returns to `ST_IDLE` on a select rise. `ST_COMMIT` lasts one cycle and returns to `ST_IDLE`.

Top module: `chain_spi_slave`

## Requirements
- R1: After reset, `sdo_oe` and `wr_stb` are both 0.
- R2: `sdo_oe` is 1 while a frame is open (select low) and 0 once select has been high for a few system clocks.
- R3: The first 16 bits seen on `sdo` in a frame are `status_word` as sampled at the select fall, bit 15 first. Each bit is valid after a rising serial clock edge and is stable until the next rising edge.
- R4: From output bit 16 on, `sdo` repeats the input bits of the same frame in the order they arrived, delayed by 16 serial clocks.
- R5: A frame of exactly 16 bits produces exactly one `wr_stb` pulse, one system clock long, after select rises. It carries `wr_addr` = received bits 15:12 and `wr_data` = received bits 11:0, where bit 15 is the first bit received.
- R6: A frame whose bit count is zero or not a multiple of 16 produces no `wr_stb`.
- R7: A frame of 32 or 48 bits produces one `wr_stb` carrying the last 16 bits received.
- R8: Clock and data activity while select is high produces no `wr_stb`, leaves `sdo_oe` at 0, and does not shift bits into the next frame.
- R9: If select falls or rises while the serial clock is high, the frame produces no `wr_stb`.
- R10: A change of `status_word` after the select fall has no effect on the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select, asynchronous |
| sck | input | 1 | Serial clock, asynchronous, idles low |
| sdi | input | 1 | Serial data in, sampled on falling `sck` |
| status_word | input | 16 | Parallel status loaded for shifting at the select fall |
| sdo | output | 1 | Serial data out, updated on rising `sck` |
| sdo_oe | output | 1 | Output driver enable for `sdo` |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_addr | output | 4 | Address field of the committed word |
| wr_data | output | 12 | Data field of the committed word |

## Verification
The hardest cases to reach from the ports are the invalid select edges: a select fall or rise that lands while the serial clock is high. The host must break its own idle-low rule to cause them, and the frame must be discarded even though it carries a well-formed 16-bit word. The stimulus reaches them with dedicated modes of the frame task. One mode raises the serial clock before dropping select. The other raises it before releasing select. The random phase also mixes these modes with frame lengths at, just off and well past the 16-bit multiples, so that the bit counter's wrap and the full-word flag are exercised together.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_BAD    = 2'd2,
        ST_COMMIT = 2'd3
    } frame_state_e;

    localparam int LANE_SEL = 0;
    localparam int LANE_SCK = 1;
    localparam int LANE_SDI = 2;
    localparam int LANES    = 3;

endpackage

// File: rtl/chain_spi_sync.sv
module chain_spi_sync #(
    parameter int               LANES   = 3,
    parameter int               STAGES  = 2,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] level_o,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    logic [LANES-1:0] prev_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
        end

        assign level_o[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level_o;
        end
    end

    assign rise_o = level_o & ~prev_q;
    assign fall_o = ~level_o & prev_q;

endmodule

// File: rtl/chain_spi_fsm.sv
module chain_spi_fsm
    import chain_spi_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_fall,
    input  logic         sel_rise,
    input  logic         sck_lvl,
    input  logic         cnt_zero,
    input  logic         word_seen,
    output frame_state_e state_o,
    output logic         load_o,
    output logic         shift_en_o,
    output logic         drive_en_o,
    output logic         commit_o
);

    frame_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_fall) begin
                    state_d = sck_lvl ? ST_BAD : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    if (!sck_lvl && cnt_zero && word_seen) begin
                        state_d = ST_COMMIT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BAD: begin
                if (sel_rise) begin
                    state_d = ST_IDLE;
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        load_o     = 1'b0;
        shift_en_o = 1'b0;
        drive_en_o = 1'b0;
        commit_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = sel_fall && !sck_lvl;
            end
            ST_SHIFT: begin
                shift_en_o = 1'b1;
                drive_en_o = 1'b1;
            end
            ST_BAD: begin
                drive_en_o = 1'b1;
            end
            ST_COMMIT: begin
                commit_o = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/chain_spi_core.sv
module chain_spi_core #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 4,
    localparam int DATA_W = WORD_W - ADDR_W,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_lvl,
    input  logic [WORD_W-1:0] status_word,
    output logic              sdo_bit,
    output logic              cnt_zero,
    output logic              word_seen,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic              sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            sdo_q  <= 1'b0;
        end else if (load) begin
            sr_q   <= status_word;
            cnt_q  <= '0;
            full_q <= 1'b0;
            sdo_q  <= status_word[WORD_W-1];
        end else if (shift_en) begin
            if (sck_fall) begin
                sr_q  <= {sr_q[WORD_W-2:0], sdi_lvl};
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    full_q <= 1'b1;
                end
            end
            if (sck_rise) begin
                sdo_q <= sr_q[WORD_W-1];
            end
        end
    end

    assign sdo_bit   = sdo_q;
    assign cnt_zero  = (cnt_q == '0);
    assign word_seen = full_q;
    assign addr_o    = sr_q[WORD_W-1 -: ADDR_W];
    assign data_o    = sr_q[DATA_W-1:0];

endmodule

// File: rtl/chain_spi_slave.sv
module chain_spi_slave
    import chain_spi_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W = WORD_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [WORD_W-1:0] status_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_SEL;

    logic [LANES-1:0] lvl, rise, fall;
    logic             sel_lvl, sel_rise, sel_fall;
    logic             sck_lvl, sck_rise, sck_fall, sdi_lvl;
    logic             load, shift_en, cnt_zero, word_seen;
    frame_state_e     state;

    chain_spi_sync #(
        .LANES  (LANES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sdi, sck, sel_n}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign sel_lvl  = lvl[LANE_SEL];
    assign sel_rise = rise[LANE_SEL];
    assign sel_fall = fall[LANE_SEL];
    assign sck_lvl  = lvl[LANE_SCK];
    assign sck_rise = rise[LANE_SCK];
    assign sck_fall = fall[LANE_SCK];
    assign sdi_lvl  = lvl[LANE_SDI];

    chain_spi_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fall  (sel_fall),
        .sel_rise  (sel_rise),
        .sck_lvl   (sck_lvl),
        .cnt_zero  (cnt_zero),
        .word_seen (word_seen),
        .state_o   (state),
        .load_o    (load),
        .shift_en_o(shift_en),
        .drive_en_o(sdo_oe),
        .commit_o  (wr_stb)
    );

    chain_spi_core #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .shift_en   (shift_en),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .sdi_lvl    (sdi_lvl),
        .status_word(status_word),
        .sdo_bit    (sdo),
        .cnt_zero   (cnt_zero),
        .word_seen  (word_seen),
        .addr_o     (wr_addr),
        .data_o     (wr_data)
    );

endmodule

// File: rtl/chain_spi_slave_chk.sv
module chain_spi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_lvl,
    input logic sel_rise,
    input logic sel_fall,
    input logic sck_lvl,
    input logic sck_rise,
    input logic cnt_zero,
    input logic sdo,
    input logic sdo_oe,
    input logic wr_stb
);

    p_no_drive_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lvl && $past(sel_lvl)) |-> !sdo_oe);

    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !sel_fall) |=> $stable(sdo));

    p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_stb_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(sel_rise) && sel_lvl));

    p_stb_whole_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cnt_zero));

    p_no_commit_clk_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && sck_lvl) |=> !wr_stb);

endmodule

bind chain_spi_slave chain_spi_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_lvl (sel_lvl),
    .sel_rise(sel_rise),
    .sel_fall(sel_fall),
    .sck_lvl (sck_lvl),
    .sck_rise(sck_rise),
    .cnt_zero(cnt_zero),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .wr_stb  (wr_stb)
);

// File: tb/chain_spi_slave_test.sv
`timescale 1ns/1ps
module chain_spi_slave_test;

    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] status_word = '0;
    logic        sdo, sdo_oe, wr_stb;
    logic [3:0]  wr_addr;
    logic [11:0] wr_data;

    int applied = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [3:0]  got_addr;
    logic [11:0] got_data;

    always #5 clk = ~clk;

    chain_spi_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sck        (sck),
        .sdi        (sdi),
        .status_word(status_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt  = stb_cnt + 1;
            got_addr = wr_addr;
            got_data = wr_data;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic expected_out(input int i, input int nbits,
                                          input logic [47:0] tx, input logic [15:0] st);
        if (i < 16) return st[15-i];
        return tx[nbits-1-(i-16)];
    endfunction

    function automatic string commit_tag(input int nbits, input int mode);
        if (mode != 0) return "R9";
        if (nbits == 0 || nbits % 16 != 0) return "R6";
        if (nbits > 16) return "R7";
        return "R5";
    endfunction

    // mode 0: legal, 1: select falls with sck high, 2: select rises with sck high
    task automatic run_frame(input int nbits, input logic [47:0] tx,
                             input logic [15:0] st, input int mode);
        int          base;
        logic        oe_open;
        logic [47:0] got_v, exp_v, m_hi, m_lo;
        logic        exp_commit;
        string       tag;
        base  = stb_cnt;
        got_v = '0;
        exp_v = '0;
        m_hi  = '0;
        m_lo  = '0;
        status_word = st;
        wait_c(H);
        if (mode == 1) begin
            sck = 1'b1;
            wait_c(H);
        end
        sel_n = 1'b0;
        wait_c(H);
        if (mode == 1) begin
            sck = 1'b0;
            wait_c(H);
        end
        oe_open = sdo_oe;
        status_word = 16'($urandom); // R10: late change must not matter
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[nbits-1-i];
            sck = 1'b1;
            wait_c(H);
            got_v[47-i] = sdo;
            exp_v[47-i] = expected_out(i, nbits, tx, st);
            if (i < 16) m_hi[47-i] = 1'b1;
            else        m_lo[47-i] = 1'b1;
            sck = 1'b0;
            wait_c(H);
        end
        if (mode == 2) begin
            sck = 1'b1;
            wait_c(H);
        end
        sel_n = 1'b1;
        wait_c(H);
        if (mode == 2) sck = 1'b0;
        wait_c(2 * H);
        check(oe_open == 1'b1, "R2 oe during frame", oe_open, 1);
        check(sdo_oe == 1'b0, "R2 oe after frame", sdo_oe, 0);
        if (mode == 0 && nbits > 0) begin
            check((got_v & m_hi) == (exp_v & m_hi), "R3/R10 status bits",
                  got_v & m_hi, exp_v & m_hi);
            if (nbits > 16)
                check((got_v & m_lo) == (exp_v & m_lo), "R4 passthrough bits",
                      got_v & m_lo, exp_v & m_lo);
        end
        exp_commit = (mode == 0) && (nbits > 0) && (nbits % 16 == 0);
        tag = commit_tag(nbits, mode);
        check((stb_cnt - base) == int'(exp_commit), {tag, " strobe count"},
              stb_cnt - base, exp_commit);
        if (exp_commit && (stb_cnt - base) == 1)
            check({got_addr, got_data} == tx[15:0], {tag, " committed word"},
                  {got_addr, got_data}, tx[15:0]);
    endtask

    task automatic idle_noise();
        int          base;
        logic        oe_seen;
        base = stb_cnt;
        oe_seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            sdi = 1'($urandom);
            sck = 1'b1;
            wait_c(H);
            oe_seen |= sdo_oe;
            sck = 1'b0;
            wait_c(H);
            oe_seen |= sdo_oe;
        end
        check(stb_cnt == base, "R8 no strobe while idle", stb_cnt - base, 0);
        check(oe_seen == 1'b0, "R8 output off while idle", oe_seen, 0);
    endtask

    initial begin
        int lens [7] = '{0, 5, 16, 17, 31, 32, 48};
        void'($urandom(32'h5EED_1234));
        wait_c(4);
        check(sdo_oe == 1'b0 && wr_stb == 1'b0, "R1 reset outputs", {sdo_oe, wr_stb}, 0);
        rst_n = 1'b1;
        wait_c(4);
        check(sdo_oe == 1'b0 && wr_stb == 1'b0, "R1 after release", {sdo_oe, wr_stb}, 0);

        run_frame(16, 48'h0000_0000_A5C3, 16'h8001, 0);   // R5
        run_frame(16, 48'h0000_0000_0000, 16'hFFFF, 0);   // R5
        run_frame(32, 48'h0000_1234_9ABC, 16'h5A5A, 0);   // R7 R4
        run_frame(48, 48'hDEAD_BEEF_F00D, 16'h0F0F, 0);   // R7 R4
        run_frame(0,  48'h0, 16'h1111, 0);                // R6
        run_frame(8,  48'h0000_0000_00FF, 16'hC3C3, 0);   // R6
        run_frame(17, 48'h0000_0001_7E7E, 16'h2468, 0);   // R6 R4
        idle_noise();                                      // R8
        run_frame(16, 48'h0000_0000_3C96, 16'h1357, 0);   // R8 next frame clean
        run_frame(16, 48'h0000_0000_4242, 16'h0000, 1);   // R9 fall edge
        run_frame(16, 48'h0000_0000_2424, 16'h0000, 2);   // R9 rise edge
        run_frame(16, 48'h0000_0000_6B6B, 16'h7777, 0);   // recovery after R9

        for (int k = 0; k < 30; k++) begin
            int          n;
            int          md;
            logic [47:0] tx;
            n  = lens[$urandom % 7];
            md = ($urandom % 6 == 0) ? int'(1 + $urandom % 2) : 0;
            tx = {16'($urandom), 32'($urandom)};
            run_frame(n, tx, 16'($urandom), md);
        end

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        applied++;
        bad++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule